// File: doc/BRIEF.md
# Three-Wire Synthesiser Word Loader

The block accepts programming words for a frequency synthesiser over three wires: a serial data line, a serial clock and a framing enable. While the enable is high, each falling serial-clock edge shifts one data bit in. The bits arrive as a 7-bit prescaler-swallow value (A), then a 10-bit main divide value (M), then an 11-bit reference divide value (R), each field most significant bit first. When the enable falls, the collected fields move into three holding registers, which drive the divider logic.

The block counts the serial-clock edges in each frame. A full 28-edge frame updates all three values. A frame of 17 to 27 edges is a fast retune: A and M come from the first 17 bits, and R keeps its old value, so clock glitches at the end of a short frame cannot corrupt the reference divider. A frame with fewer than 17 edges is dropped and flagged. The three pins are asynchronous to the system clock. They pass through synchronisers before their edges are detected.

Top module: `synth_prog_loader`

## Requirements
- R1: After reset, A reads 0, M reads 8, R reads 3, and the strobe and error outputs are low.
- R2: A bit is captured only on a falling edge of the serial clock while the enable is high. The first bit of a frame is A bit 6, bit 7 is M bit 9, and bit 17 is R bit 10, each field sent MSB first.
- R3: When the enable falls after exactly 28 counted edges, A, M and R all take the received values, and the strobe is high for exactly one system clock.
- R4: When the enable falls after 17 to 27 counted edges, A and M take bits 0..16 of the frame, R is unchanged, and the strobe pulses once.
- R5: Serial-clock edges and data while the enable is low have no effect on the stored fields or the edge count, and produce no strobe.
- R6: The edge count saturates at 28. Edges beyond the 28th are ignored, so R holds frame bits 17..27.
- R7: A frame with fewer than 17 edges changes no output value, gives no strobe, and pulses the error output for one system clock.
- R8: A full frame whose R field is below 3 updates A and M and pulses the strobe, keeps the old R, and pulses the error output. R = 3 and R = 2047 are accepted.
- R9: The held values and the strobe change on the third rising system clock edge at which the enable is sampled low, counting the first such edge.
- R10: Each rising edge of the enable restarts the edge count from zero, so edges from an earlier frame never carry into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data_i | input | 1 | Serial data line, asynchronous |
| ser_clk_i | input | 1 | Serial clock; bits are taken on its falling edge |
| ser_en_i | input | 1 | Frame enable; a falling edge commits the frame |
| a_word_o | output | 7 | Held A value |
| m_word_o | output | 10 | Held M value |
| r_word_o | output | 11 | Held R value |
| load_strobe_o | output | 1 | One-cycle pulse when a frame is committed |
| load_err_o | output | 1 | One-cycle pulse for a dropped frame or a rejected R |

## Verification
The hardest cases to reach are frames whose edge count is neither 17 nor 28: an overlong frame, whose extra edges would push R out of alignment if the count did not saturate, and a 22-edge frame, whose surplus bits land where R would sit. The bench drives the pins with a task that takes any edge count and a left-aligned bit pattern. It chooses the surplus bits so that a wrongly taken R, or a shift past the cap, gives a value that differs from the expected one. Serial-clock pulses with the enable low are placed just before a short frame, so that any leak would show in the next committed A and M.

// File: rtl/synth_prog_pkg.sv
`timescale 1ns/1ps
package synth_prog_pkg;
  // bit positions inside the synchronised pin vector
  localparam int PIN_DATA  = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_EN    = 2;
  localparam int PIN_COUNT = 3;

  // what a closing enable edge does with the collected frame
  typedef enum logic [1:0] {
    FRAME_NONE    = 2'd0,
    FRAME_DISCARD = 2'd1,
    FRAME_SHORT   = 2'd2,
    FRAME_FULL    = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/pin_sync.sv
`timescale 1ns/1ps
module pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] lvl_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], pins_i[g]};
    end
    assign lvl_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/bit_collector.sv
`timescale 1ns/1ps
module bit_collector #(
  parameter int HEAD_LEN = 17,
  parameter int TAIL_LEN = 11,
  localparam int FULL_LEN = HEAD_LEN + TAIL_LEN,
  localparam int CNT_W    = $clog2(FULL_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                win_i,
  input  logic                tick_i,
  input  logic                bit_i,
  output logic [HEAD_LEN-1:0] head_o,
  output logic [TAIL_LEN-1:0] tail_o,
  output logic [CNT_W-1:0]    cnt_o
);
  logic [HEAD_LEN-1:0] head_q;
  logic [TAIL_LEN-1:0] tail_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                take;
  logic                in_head;

  assign take    = win_i && tick_i && (cnt_q < CNT_W'(FULL_LEN));
  assign in_head = cnt_q < CNT_W'(HEAD_LEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_head) head_q <= {head_q[HEAD_LEN-2:0], bit_i};
      else         tail_q <= {tail_q[TAIL_LEN-2:0], bit_i};
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;

  a_r6_cnt_cap: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FULL_LEN));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !win_i |=> $stable(cnt_q));
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cnt_q == '0));
endmodule

// File: rtl/word_commit.sv
`timescale 1ns/1ps
module word_commit
  import synth_prog_pkg::*;
#(
  parameter int A_W    = 7,
  parameter int M_W    = 10,
  parameter int R_W    = 11,
  parameter int R_MIN  = 3,
  parameter int A_INIT = 0,
  parameter int M_INIT = 8,
  parameter int R_INIT = 3,
  localparam int HEAD_LEN = A_W + M_W,
  localparam int FULL_LEN = HEAD_LEN + R_W,
  localparam int CNT_W    = $clog2(FULL_LEN + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                close_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [HEAD_LEN-1:0] head_i,
  input  logic [R_W-1:0]      tail_i,
  output logic [A_W-1:0]      a_o,
  output logic [M_W-1:0]      m_o,
  output logic [R_W-1:0]      r_o,
  output logic                strobe_o,
  output logic                err_o
);
  frame_kind_e kind;
  logic        r_ok;

  always_comb begin
    kind = FRAME_NONE;
    if (close_i) begin
      if (cnt_i < CNT_W'(HEAD_LEN))      kind = FRAME_DISCARD;
      else if (cnt_i == CNT_W'(FULL_LEN)) kind = FRAME_FULL;
      else                                kind = FRAME_SHORT;
    end
  end

  assign r_ok = tail_i >= R_W'(R_MIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_o      <= A_W'(A_INIT);
      m_o      <= M_W'(M_INIT);
      r_o      <= R_W'(R_INIT);
      strobe_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      err_o    <= 1'b0;
      case (kind)
        FRAME_DISCARD: err_o <= 1'b1;
        FRAME_SHORT, FRAME_FULL: begin
          a_o      <= head_i[HEAD_LEN-1:M_W];
          m_o      <= head_i[M_W-1:0];
          strobe_o <= 1'b1;
          if (kind == FRAME_FULL) begin
            if (r_ok) r_o   <= tail_i;
            else      err_o <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: rtl/synth_prog_loader.sv
`timescale 1ns/1ps
module synth_prog_loader
  import synth_prog_pkg::*;
#(
  parameter int A_W         = 7,
  parameter int M_W         = 10,
  parameter int R_W         = 11,
  parameter int SYNC_STAGES = 2,
  parameter int R_MIN       = 3,
  parameter int A_INIT      = 0,
  parameter int M_INIT      = 8,
  parameter int R_INIT      = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ser_data_i,
  input  logic           ser_clk_i,
  input  logic           ser_en_i,
  output logic [A_W-1:0] a_word_o,
  output logic [M_W-1:0] m_word_o,
  output logic [R_W-1:0] r_word_o,
  output logic           load_strobe_o,
  output logic           load_err_o
);
  localparam int HEAD_LEN = A_W + M_W;
  localparam int FULL_LEN = HEAD_LEN + R_W;
  localparam int CNT_W    = $clog2(FULL_LEN + 1);

  logic [PIN_COUNT-1:0] pins, lvl;
  logic                 en_prev, sclk_prev;
  logic                 en_rise, en_fall, sclk_fall;
  logic [HEAD_LEN-1:0]  head;
  logic [R_W-1:0]       tail;
  logic [CNT_W-1:0]     cnt;

  always_comb begin
    pins           = '0;
    pins[PIN_DATA] = ser_data_i;
    pins[PIN_SCLK] = ser_clk_i;
    pins[PIN_EN]   = ser_en_i;
  end

  pin_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pins_i(pins), .lvl_o(lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev   <= 1'b0;
      sclk_prev <= 1'b0;
    end else begin
      en_prev   <= lvl[PIN_EN];
      sclk_prev <= lvl[PIN_SCLK];
    end
  end

  assign en_rise   =  lvl[PIN_EN]   && !en_prev;
  assign en_fall   = !lvl[PIN_EN]   &&  en_prev;
  assign sclk_fall = !lvl[PIN_SCLK] &&  sclk_prev;

  bit_collector #(.HEAD_LEN(HEAD_LEN), .TAIL_LEN(R_W)) u_collect (
    .clk(clk), .rst(rst), .start_i(en_rise), .win_i(lvl[PIN_EN]),
    .tick_i(sclk_fall), .bit_i(lvl[PIN_DATA]),
    .head_o(head), .tail_o(tail), .cnt_o(cnt)
  );

  word_commit #(
    .A_W(A_W), .M_W(M_W), .R_W(R_W), .R_MIN(R_MIN),
    .A_INIT(A_INIT), .M_INIT(M_INIT), .R_INIT(R_INIT)
  ) u_commit (
    .clk(clk), .rst(rst), .close_i(en_fall), .cnt_i(cnt),
    .head_i(head), .tail_i(tail),
    .a_o(a_word_o), .m_o(m_word_o), .r_o(r_word_o),
    .strobe_o(load_strobe_o), .err_o(load_err_o)
  );

  a_r4_r_hold: assert property (@(posedge clk) disable iff (rst)
    !load_strobe_o |-> $stable(r_word_o));
  a_r7_am_hold: assert property (@(posedge clk) disable iff (rst)
    !load_strobe_o |-> ($stable(a_word_o) && $stable(m_word_o)));
  a_r8_r_floor: assert property (@(posedge clk) disable iff (rst)
    r_word_o >= R_W'(R_MIN));
  a_r5_no_idle_strobe: assert property (@(posedge clk) disable iff (rst)
    (!lvl[PIN_EN] && !en_prev) |=> !load_strobe_o);
endmodule

// File: tb/synth_prog_loader_test.sv
`timescale 1ns/1ps
module synth_prog_loader_test;
  logic clk = 1'b0, rst = 1'b1;
  logic sdata = 1'b0, sclk = 1'b0, sen = 1'b0;
  logic [6:0]  a_o;
  logic [9:0]  m_o;
  logic [10:0] r_o;
  logic        stb, err;
  int checks = 0, failures = 0;
  int n_stb = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  synth_prog_loader uut (
    .clk(clk), .rst(rst), .ser_data_i(sdata), .ser_clk_i(sclk), .ser_en_i(sen),
    .a_word_o(a_o), .m_word_o(m_o), .r_word_o(r_o),
    .load_strobe_o(stb), .load_err_o(err)
  );

  // behavioural reference model, advanced on every rising edge
  logic [2:0] hist[$];               // {en, sclk, data} per sampled edge
  int  mc, mhead, mtail, ma, mm, mr;
  bit  mstb, merr;
  always @(posedge clk) begin
    if (rst) begin
      hist = '{3'b000, 3'b000, 3'b000};
      mc = 0; mhead = 0; mtail = 0; ma = 0; mm = 8; mr = 3; mstb = 0; merr = 0;
    end else begin
      logic [2:0] cur, prv;
      cur = hist[1]; prv = hist[0];
      mstb = 0; merr = 0;
      if (cur[2] && !prv[2]) mc = 0;
      else if (cur[2] && prv[1] && !cur[1] && mc < 28) begin
        if (mc < 17) mhead = ((mhead << 1) | cur[0]) & 32'h1FFFF;
        else         mtail = ((mtail << 1) | cur[0]) & 2047;
        mc++;
      end else if (!cur[2] && prv[2]) begin
        if (mc < 17) merr = 1;
        else begin
          ma = mhead >> 10; mm = mhead & 1023; mstb = 1;
          if (mc == 28) begin
            if (mtail >= 3) mr = mtail; else merr = 1;
          end
        end
      end
      hist.delete(0);
      hist.push_back({sen, sclk, sdata});
    end
  end

  // per-cycle comparison against the model (R9 timing)
  always @(negedge clk) if (!rst && !done) begin
    checks++;
    if (a_o != ma || m_o != mm || r_o != mr || stb != mstb || err != merr) begin
      failures++;
      $display("FAIL R9 cycle compare: got a=%0d m=%0d r=%0d stb=%0b err=%0b exp a=%0d m=%0d r=%0d stb=%0b err=%0b",
               a_o, m_o, r_o, stb, err, ma, mm, mr, mstb, merr);
    end
    if (stb) n_stb++;
    if (err) n_err++;
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] pack(int a, int m, int r);
    logic [6:0] av = a[6:0];
    logic [9:0] mv = m[9:0];
    logic [10:0] rv = r[10:0];
    return {av, mv, rv, 4'b0000};
  endfunction

  // sends n bits, bit i taken from w[31-i]; enable left high
  task automatic frame_bits(logic [31:0] w, int n);
    sen = 1'b1; cyc(3);
    for (int i = 0; i < n; i++) begin
      sdata = w[31-i]; cyc(2);
      sclk = 1'b1; cyc(3);
      sclk = 1'b0; cyc(3);
    end
    cyc(3);
  endtask

  task automatic close_frame;
    sen = 1'b0; cyc(6);
  endtask

  task automatic load(logic [31:0] w, int n);
    frame_bits(w, n); close_frame();
  endtask

  initial begin
    int s0, e0;
    cyc(4); rst = 1'b0; cyc(2);
    // R1 reset state
    check("R1 a", a_o, 0); check("R1 m", m_o, 8); check("R1 r", r_o, 3);
    check("R1 stb", stb, 0); check("R1 err", err, 0);

    // R2 R3 full frame
    s0 = n_stb;
    load(pack(85, 343, 400), 28);
    check("R2 a order", a_o, 85); check("R2 m order", m_o, 343);
    check("R3 r", r_o, 400); check("R3 one strobe", n_stb - s0, 1);

    // R4 short frame of 17 edges
    load(pack(48, 100, 0), 17);
    check("R4 a", a_o, 48); check("R4 m", m_o, 100); check("R4 r kept", r_o, 400);

    // R4 22-edge frame, surplus bits set
    load(pack(5, 200, 11'h7C0), 22);
    check("R4 a 22", a_o, 5); check("R4 m 22", m_o, 200); check("R4 r kept 22", r_o, 400);

    // R5 serial clock with enable low
    s0 = n_stb; sdata = 1'b1;
    for (int i = 0; i < 10; i++) begin sclk = 1'b1; cyc(3); sclk = 1'b0; cyc(3); end
    cyc(4);
    check("R5 no strobe", n_stb - s0, 0); check("R5 a unchanged", a_o, 5);
    load(pack(1, 9, 0), 17);
    check("R5 a after idle", a_o, 1); check("R5 m after idle", m_o, 9);

    // R6 overlong frame
    load(pack(3, 77, 1000) | 32'h0000_000C, 30);
    check("R6 a", a_o, 3); check("R6 m", m_o, 77); check("R6 r capped", r_o, 1000);

    // R7 too short
    s0 = n_stb; e0 = n_err;
    load(pack(120, 900, 0), 10);
    check("R7 err", n_err - e0, 1); check("R7 no strobe", n_stb - s0, 0);
    check("R7 a", a_o, 3); check("R7 m", m_o, 77); check("R7 r", r_o, 1000);

    // R8 R below floor; R10 count restarted after discarded frame
    s0 = n_stb; e0 = n_err;
    load(pack(9, 500, 2), 28);
    check("R10 a fresh count", a_o, 9); check("R8 m", m_o, 500);
    check("R8 r kept", r_o, 1000); check("R8 err", n_err - e0, 1);
    check("R8 strobe", n_stb - s0, 1);

    // R8 boundary R = 3
    e0 = n_err;
    load(pack(10, 20, 3), 28);
    check("R8 r=3", r_o, 3); check("R8 no err", n_err - e0, 0);

    // R9 latency and R8 upper bound
    frame_bits(pack(127, 1023, 2047), 28);
    sen = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R9 old r", r_o, 3);
    @(negedge clk);
    check("R9 new r", r_o, 2047); check("R9 strobe", stb, 1);
    check("R9 a", a_o, 127); check("R9 m", m_o, 1023);
    cyc(5);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule